// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a chain of boundary cells that sits between the core logic and the chip pads. Every cell holds two bits: a shift stage, which either captures the cell's functional value or takes serial data from its neighbour on the rising test clock, and a holding stage, which copies the shift stage on the falling test clock when an update strobe is present. Only the holding stage ever drives a pin in test mode. While a new pattern is streamed through the shift stages, pads and core inputs therefore keep the previous pattern until the update.

The chain has a group of input-pad cells followed by a group of output-pad cells. An external test access controller supplies the capture, shift and update strobes. Two mode selects, one for each group, choose between the functional path and the holding stage. An input cell routes either the pad value or its holding stage to the core input. An output cell routes either the core output or its holding stage to the pad. An active-low asynchronous test reset clears both stages of every cell. The reset is released in step with the test clock.

Top module: `bscan_chain`

## Requirements
- R1: While trst_n is low, every shift stage and every holding stage is 0, so scan_out is 0 and both test-mode pin groups read 0. After trst_n rises, the stages stay cleared until two rising test-clock edges have passed.
- R2: With out_test_mode low, pad_out equals core_out combinationally. With in_test_mode low, core_in equals pad_in combinationally.
- R3: On a rising tck with capture_en high and shift_en low, each shift stage loads its parallel value. Chain position k (0 to N_IN-1) loads pad_in[k], and position N_IN+j loads core_out[j].
- R4: On a rising tck with shift_en high, position 0 loads scan_in and every other position p loads the old value of position p-1. scan_out always shows the shift stage of the last position, N_IN+N_OUT-1.
- R5: On a rising tck with capture_en and shift_en both low, every shift stage keeps its value.
- R6: When capture_en and shift_en are both high, the shift behaviour of R4 applies.
- R7: A holding stage loads its shift stage only on a falling tck with update_en high. At every other time it keeps its value, so shifting never moves the pins in test mode.
- R8: With out_test_mode high, pad_out[j] equals the holding stage of chain position N_IN+j.
- R9: With in_test_mode high, core_in[k] equals the holding stage of chain position k. The two mode selects act independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; shift stages use the rising edge, holding stages the falling edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| capture_en | input | 1 | Parallel load of the shift stages |
| shift_en | input | 1 | Serial shift of the chain; overrides capture_en |
| update_en | input | 1 | Copy shift stages into holding stages on the falling edge |
| out_test_mode | input | 1 | Output-pad cells drive pads from their holding stages |
| in_test_mode | input | 1 | Input-pad cells drive core inputs from their holding stages |
| scan_in | input | 1 | Serial data into chain position 0 |
| scan_out | output | 1 | Serial data from the last chain position |
| core_out | input | N_OUT | Values produced by the core for the output pads |
| pad_out | output | N_OUT | Values driven to the output pads |
| pad_in | input | N_IN | Values arriving from the input pads |
| core_in | output | N_IN | Values delivered to the core inputs |

## Verification
The clocked properties take two things for granted. Strobes and data inputs are settled around each test-clock edge. update_en is sampled only on falling edges, and shift_en and capture_en only on rising edges. The properties are disabled until the synchronized reset has released. The stimulus changes every input just after a rising edge. The update strobe is held across exactly one falling edge, and the bench waits out the two-edge reset release before it expects any strobe to act.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // strobes delivered by the test access controller to every cell
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } bs_ctrl_t;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic     tck,
  input  logic     rst_n,
  input  bs_ctrl_t ctrl,
  input  logic     test_mode,
  input  logic     ser_in,
  input  logic     par_in,
  output logic     ser_out,
  output logic     hold_out,
  output logic     sys_out
);

  logic shift_q;
  logic shift_d;
  logic shift_ce;
  logic hold_q;

  // next-state for the shift stage: serial path wins over capture
  always_comb begin
    shift_ce = ctrl.shift | ctrl.capture;
    shift_d  = shift_q;
    if (ctrl.shift) begin
      shift_d = ser_in;
    end else if (ctrl.capture) begin
      shift_d = par_in;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= 1'b0;
    end else if (shift_ce) begin
      shift_q <= shift_d;
    end
  end

  // holding stage moves on the opposite edge, only under update
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (ctrl.update) begin
      hold_q <= shift_q;
    end
  end

  assign ser_out  = shift_q;
  assign hold_out = hold_q;
  assign sys_out  = test_mode ? hold_q : par_in;

endmodule

// File: rtl/bscan_group.sv
module bscan_group
  import bscan_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             tck,
  input  logic             rst_n,
  input  bs_ctrl_t         ctrl,
  input  logic             test_mode,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] shift_vec,
  output logic [WIDTH-1:0] hold_vec,
  output logic [WIDTH-1:0] sys_out
);

  logic [WIDTH:0] link;

  assign link[0] = ser_in;

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    bscan_cell u_cell (
      .tck       (tck),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .test_mode (test_mode),
      .ser_in    (link[g]),
      .par_in    (par_in[g]),
      .ser_out   (link[g+1]),
      .hold_out  (hold_vec[g]),
      .sys_out   (sys_out[g])
    );
  end

  assign shift_vec = link[WIDTH:1];
  assign ser_out   = link[WIDTH];

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned N_OUT = 4
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             out_test_mode,
  input  logic             in_test_mode,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pad_out,
  input  logic [N_IN-1:0]  pad_in,
  output logic [N_IN-1:0]  core_in
);

  localparam int unsigned LEN = N_IN + N_OUT;

  bs_ctrl_t       ctrl;
  logic           rst_sync_n;
  logic           mid_link;
  logic [LEN-1:0] shift_q;
  logic [LEN-1:0] hold_q;

  assign ctrl = '{capture: capture_en, shift: shift_en, update: update_en};

  bscan_rst_sync #(
    .STAGES (RST_SYNC_STAGES)
  ) u_rst_sync (
    .tck        (tck),
    .trst_n     (trst_n),
    .rst_sync_n (rst_sync_n)
  );

  // input-pad cells occupy chain positions 0 .. N_IN-1
  bscan_group #(
    .WIDTH (N_IN)
  ) u_in_grp (
    .tck       (tck),
    .rst_n     (rst_sync_n),
    .ctrl      (ctrl),
    .test_mode (in_test_mode),
    .ser_in    (scan_in),
    .par_in    (pad_in),
    .ser_out   (mid_link),
    .shift_vec (shift_q[N_IN-1:0]),
    .hold_vec  (hold_q[N_IN-1:0]),
    .sys_out   (core_in)
  );

  // output-pad cells follow at positions N_IN .. LEN-1
  bscan_group #(
    .WIDTH (N_OUT)
  ) u_out_grp (
    .tck       (tck),
    .rst_n     (rst_sync_n),
    .ctrl      (ctrl),
    .test_mode (out_test_mode),
    .ser_in    (mid_link),
    .par_in    (core_out),
    .ser_out   (scan_out),
    .shift_vec (shift_q[LEN-1:N_IN]),
    .hold_vec  (hold_q[LEN-1:N_IN]),
    .sys_out   (pad_out)
  );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned N_OUT = 4
) (
  input logic                  tck,
  input logic                  rst_sync_n,
  input logic                  capture_en,
  input logic                  shift_en,
  input logic                  update_en,
  input logic                  out_test_mode,
  input logic                  in_test_mode,
  input logic                  scan_in,
  input logic                  scan_out,
  input logic [N_OUT-1:0]      core_out,
  input logic [N_OUT-1:0]      pad_out,
  input logic [N_IN-1:0]       pad_in,
  input logic [N_IN-1:0]       core_in,
  input logic [N_IN+N_OUT-1:0] shift_q,
  input logic [N_IN+N_OUT-1:0] hold_q
);

  localparam int unsigned LEN = N_IN + N_OUT;

  // R2
  out_pass_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    !out_test_mode |-> pad_out == core_out);

  // R2
  in_pass_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    !in_test_mode |-> core_in == pad_in);

  // R3
  capture_load_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (capture_en && !shift_en) |=> shift_q == $past({core_out, pad_in}));

  // R4
  shift_head_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    shift_en |=> shift_q[0] == $past(scan_in));

  // R4 R6
  shift_body_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    shift_en |=> shift_q[LEN-1:1] == $past(shift_q[LEN-2:0]));

  // R4
  shift_tail_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    shift_en |=> scan_out == $past(shift_q[LEN-2]));

  // R5
  idle_hold_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (!capture_en && !shift_en) |=> $stable(shift_q));

  // R7
  update_copy_chk: assert property (@(negedge tck) disable iff (!rst_sync_n)
    update_en |=> hold_q == $past(shift_q));

  // R7
  no_update_chk: assert property (@(negedge tck) disable iff (!rst_sync_n)
    !update_en |=> $stable(hold_q));

  // R8
  out_test_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    out_test_mode |-> pad_out == hold_q[LEN-1:N_IN]);

  // R9
  in_test_chk: assert property (@(posedge tck) disable iff (!rst_sync_n)
    in_test_mode |-> core_in == hold_q[N_IN-1:0]);

endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (.*);

// File: tb/test_bscan_chain.sv
module test_bscan_chain;

  localparam int unsigned N_IN   = 3;
  localparam int unsigned N_OUT  = 4;
  localparam int unsigned LEN    = N_IN + N_OUT;
  localparam int unsigned PERIOD = 10;

  logic             tck = 1'b0;
  logic             trst_n = 1'b0;
  logic             capture_en = 1'b0;
  logic             shift_en = 1'b0;
  logic             update_en = 1'b0;
  logic             out_test_mode = 1'b0;
  logic             in_test_mode = 1'b0;
  logic             scan_in = 1'b0;
  logic             scan_out;
  logic [N_OUT-1:0] core_out = '0;
  logic [N_OUT-1:0] pad_out;
  logic [N_IN-1:0]  pad_in = '0;
  logic [N_IN-1:0]  core_in;

  logic [LEN-1:0] m_sh = '0;
  logic [LEN-1:0] m_hd = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) i_bscan_chain (
    .tck (tck), .trst_n (trst_n), .capture_en (capture_en),
    .shift_en (shift_en), .update_en (update_en),
    .out_test_mode (out_test_mode), .in_test_mode (in_test_mode),
    .scan_in (scan_in), .scan_out (scan_out),
    .core_out (core_out), .pad_out (pad_out),
    .pad_in (pad_in), .core_in (core_in)
  );

  always #(PERIOD/2) tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    #1;
  endtask

  task automatic chk_pins(input string req);
    logic [N_OUT-1:0] exp_pad;
    logic [N_IN-1:0]  exp_core;
    exp_pad  = out_test_mode ? m_hd[LEN-1:N_IN] : core_out;
    exp_core = in_test_mode ? m_hd[N_IN-1:0] : pad_in;
    chk({req, " pad_out"}, 32'(pad_out), 32'(exp_pad));
    chk({req, " core_in"}, 32'(core_in), 32'(exp_core));
  endtask

  // one rising edge with the given strobes; bench model follows the requirements
  task automatic strobe(input logic cap, input logic shf, input logic sin);
    capture_en = cap;
    shift_en   = shf;
    scan_in    = sin;
    tick();
    if (shf) m_sh = {m_sh[LEN-2:0], sin};
    else if (cap) m_sh = {core_out, pad_in};
    capture_en = 1'b0;
    shift_en   = 1'b0;
    #1;
  endtask

  task automatic shift_seq(input logic [LEN-1:0] bits, input string req);
    for (int i = 0; i < int'(LEN); i++) begin
      strobe(1'b0, 1'b1, bits[i]);
      chk({req, " scan_out"}, 32'(scan_out), 32'(m_sh[LEN-1]));
      chk_pins({req, " R7 pins frozen during shift"});
    end
  endtask

  task automatic do_update(input string req);
    update_en = 1'b1;
    #1;
    chk_pins({req, " R7 before falling edge"});
    @(negedge tck);
    #1;
    m_hd = m_sh;
    update_en = 1'b0;
    chk_pins({req, " after update"});
  endtask

  task automatic t_reset();
    trst_n = 1'b0;
    #1;
    m_sh = '0;
    m_hd = '0;
    out_test_mode = 1'b1;
    in_test_mode  = 1'b1;
    #1;
    chk("R1 scan_out in reset", 32'(scan_out), 32'd0);
    chk_pins("R1 in reset");
    tick();
    trst_n = 1'b1;
    // capture attempt during synchronized release must have no effect
    pad_in = '1;
    core_out = '1;
    strobe(1'b1, 1'b0, 1'b0);
    m_sh = '0;
    chk("R1 held during release", 32'(scan_out), 32'd0);
    tick();
    tick();
  endtask

  task automatic t_normal();
    out_test_mode = 1'b0;
    in_test_mode  = 1'b0;
    for (int i = 0; i < 4; i++) begin
      core_out = N_OUT'(32'h5 + i * 3);
      pad_in   = N_IN'(32'h6 ^ i);
      #1;
      chk_pins("R2 pass-through");
    end
  endtask

  task automatic t_capture();
    core_out = N_OUT'(4'b1011);
    pad_in   = N_IN'(3'b010);
    strobe(1'b1, 1'b0, 1'b0);
    chk("R3 capture tail", 32'(scan_out), 32'(core_out[N_OUT-1]));
    shift_seq('0, "R3 R4 capture unload");
    chk("R4 chain emptied", 32'(scan_out), 32'd0);
  endtask

  task automatic t_shift_update();
    out_test_mode = 1'b1;
    in_test_mode  = 1'b1;
    shift_seq(LEN'(7'b1101001), "R4 load");
    do_update("R8 R9");
    shift_seq(LEN'(7'b0110110), "R4 reload");
    do_update("R8 R9 second");
  endtask

  task automatic t_hold();
    logic keep;
    keep = scan_out;
    for (int i = 0; i < 5; i++) begin
      core_out = N_OUT'(i);
      pad_in   = N_IN'(~i);
      strobe(1'b0, 1'b0, 1'b1);
      chk("R5 idle scan_out", 32'(scan_out), 32'(keep));
    end
    shift_seq('0, "R5 retained contents");
  endtask

  task automatic t_priority();
    core_out = '1;
    pad_in   = '1;
    strobe(1'b1, 1'b1, 1'b0);
    chk("R6 shift over capture", 32'(scan_out), 32'(m_sh[LEN-1]));
    shift_seq('0, "R6 unload");
  endtask

  task automatic t_mode_split();
    shift_seq(LEN'(7'b1010101), "R9 load");
    do_update("R9 split");
    out_test_mode = 1'b1;
    in_test_mode  = 1'b0;
    pad_in = N_IN'(3'b110);
    #1;
    chk_pins("R8 R9 out test in normal");
    out_test_mode = 1'b0;
    in_test_mode  = 1'b1;
    core_out = N_OUT'(4'b0011);
    #1;
    chk_pins("R8 R9 in test out normal");
  endtask

  task automatic t_midrun_reset();
    out_test_mode = 1'b1;
    in_test_mode  = 1'b1;
    #1;
    chk_pins("R1 before mid reset");
    t_reset();
    chk_pins("R1 after mid reset");
    chk("R1 scan_out after mid reset", 32'(scan_out), 32'd0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_capture();
    t_shift_update();
    t_hold();
    t_priority();
    t_mode_split();
    t_midrun_reset();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule